// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the byte-wide host register interface of a telephony and audio peripheral. It decodes eight direct byte offsets. Offset 0 works in two ways. A write to it stores the number of an internal register. A read from it returns the pending interrupt sources. Offset 1 is the data window, and it moves bytes to and from whichever internal register the last command selected.

The block holds the internal configuration registers of three groups:

- the start-up control register;
- the two channel-multiplexer registers;
- the audio-path registers: four sixteen-bit gain words and two mode bytes.

A gain word is loaded with two consecutive data-port accesses after one command write, low byte first. Every register value leaves the block on dedicated output ports for the neighbouring logic. The block also collects one-cycle event pulses from eight sources into a status byte, which is cleared when the host reads it. From that status byte it drives a level interrupt request.

Top module: `irp_top`

## Requirements
- R1: After reset every configuration output is zero, the start-up register's mode field (bits 1:0) reads 0 (idle), `irqOut` is low, a read of offset 0 returns 0x00, and `busRdata` is 0x00 whenever `busRd` is low.
- R2: A write to offset 0 selects an internal register. A following write to offset 1 stores the byte into it, and a read of offset 1 returns it. The single-byte registers are:
  - 0x21 start-up control (`initReg`);
  - 0x41 channel routing (`muxRoute`);
  - 0x44 channel control (`muxCtl`);
  - 0x69 audio mode 1 (`apMode1`);
  - 0x6A audio mode 2 (`apMode2`).
- R3: The sixteen-bit gain registers are 0x63 transmit (`txGain`), 0x64 receive (`rxGain`), 0x65 extra receive (`extGain`) and 0x66 sidetone (`sideGain`). After a command write, the first data access goes to bits 7:0 and the second to bits 15:8. This holds for both writes and reads.
- R4: A command write returns the byte pointer to the low byte, even when the same register number is written again.
- R5: A read of any other register number through offset 1 returns 0x00, and a write of such a number changes no output.
- R6: Each bit of `irqSrc` that pulses high sets the same bit of the pending byte. The bit encoding is:
  - bit 0: D transmit threshold;
  - bit 1: D receive threshold;
  - bit 2: D packet status;
  - bit 3: D error;
  - bit 4: B-channel transfer;
  - bit 5: line status;
  - bit 6: D buffer status;
  - bit 7: multiframe.

  A read of offset 0 returns the pending byte in that cycle and clears it.
- R7: A source pulse in the same cycle as the clearing read is not lost. It is absent from the value returned and remains pending afterwards.
- R8: `irqOut` is high exactly while some pending bit is set and bit 2 (value 0x04) of the start-up register is clear. While that bit is set, pending bits are kept, and they raise `irqOut` again once the bit is cleared.
- R9: Writes to offsets 2 to 7 change no output and do not move the byte pointer. Reads of offsets 2 to 7 return 0x00.
- R10: A third data access after one command write wraps back to the low byte of a gain register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Direct byte offset |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of `busRd` |
| irqSrc | input | 8 | One-cycle interrupt source events |
| irqOut | output | 1 | Level interrupt request |
| initReg | output | 8 | Start-up control register (0x21) |
| muxRoute | output | 8 | Channel routing register (0x41) |
| muxCtl | output | 8 | Channel control register (0x44) |
| apMode1 | output | 8 | Audio mode register 1 (0x69) |
| apMode2 | output | 8 | Audio mode register 2 (0x6A) |
| txGain | output | 16 | Transmit gain (0x63) |
| rxGain | output | 16 | Receive gain (0x64) |
| extGain | output | 16 | Extra receive gain (0x65) |
| sideGain | output | 16 | Sidetone gain (0x66) |

## Verification
The hardest case to reach from the ports is a source pulse that lands in the very cycle of the clearing status read. The bench reaches it by driving `irqSrc` in the same half-cycle as the offset-0 read strobe. It then checks that the returned byte excludes the new bit and that `irqOut` stays high afterwards.

A second hard-to-reach state is the byte pointer left at the high half. The bench reaches it by re-issuing a command after one data byte, and by making three data writes after one command. Every one of the 256 register numbers is written and read back against an arithmetic pattern, so any stray decode shows up as a wrong value or a changed output.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int GAIN_N = 4;
  localparam int GAIN_W = 2 * BYTE_W;

  // direct offsets
  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd1;

  // indirect register numbers
  localparam logic [BYTE_W-1:0] RN_INIT      = 8'h21;
  localparam logic [BYTE_W-1:0] RN_MUX_ROUTE = 8'h41;
  localparam logic [BYTE_W-1:0] RN_MUX_CTL   = 8'h44;
  localparam logic [BYTE_W-1:0] RN_GAIN_BASE = 8'h63;
  localparam logic [BYTE_W-1:0] RN_MODE1     = 8'h69;
  localparam logic [BYTE_W-1:0] RN_MODE2     = 8'h6A;

  localparam int INIT_IRQ_OFF_BIT = 2;

  typedef struct packed {
    logic              dataWr;
    logic              dataRd;
    logic              irqRd;
    logic              hiByte;
    logic [BYTE_W-1:0] regSel;
  } strobe_t;
endpackage

// File: rtl/irp_ctrl.sv
module irp_ctrl
  import irp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output strobe_t           stb
);
  logic [BYTE_W-1:0] cmdQ;
  logic              ptrQ;
  logic              cmdHit;
  logic              dataWr;
  logic              dataRd;

  assign cmdHit = busWr && (busAddr == OFF_CMD);
  assign dataWr = busWr && (busAddr == OFF_DATA);
  assign dataRd = busRd && !busWr && (busAddr == OFF_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0;
      ptrQ <= 1'b0;
    end else if (cmdHit) begin
      cmdQ <= busWdata;
      ptrQ <= 1'b0;
    end else if (dataWr || dataRd) begin
      ptrQ <= ~ptrQ;
    end
  end

  always_comb begin
    stb.dataWr = dataWr;
    stb.dataRd = dataRd;
    stb.irqRd  = busRd && !busWr && (busAddr == OFF_CMD);
    stb.hiByte = ptrQ;
    stb.regSel = cmdQ;
  end
endmodule

// File: rtl/irp_datapath.sv
module irp_datapath
  import irp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic [BYTE_W-1:0]            irqSrc,
  output logic [BYTE_W-1:0]            rdata,
  output logic                         irqOut,
  output logic [BYTE_W-1:0]            initQ,
  output logic [BYTE_W-1:0]            muxRouteQ,
  output logic [BYTE_W-1:0]            muxCtlQ,
  output logic [BYTE_W-1:0]            mode1Q,
  output logic [BYTE_W-1:0]            mode2Q,
  output logic [GAIN_N-1:0][GAIN_W-1:0] gainVec
);
  logic [BYTE_W-1:0] pendQ;
  logic [BYTE_W-1:0] rdByte;

  // single-byte registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initQ     <= '0;
      muxRouteQ <= '0;
      muxCtlQ   <= '0;
      mode1Q    <= '0;
      mode2Q    <= '0;
    end else if (stb.dataWr) begin
      case (stb.regSel)
        RN_INIT:      initQ     <= wdata;
        RN_MUX_ROUTE: muxRouteQ <= wdata;
        RN_MUX_CTL:   muxCtlQ   <= wdata;
        RN_MODE1:     mode1Q    <= wdata;
        RN_MODE2:     mode2Q    <= wdata;
        default: ;
      endcase
    end
  end

  // two-byte gain words
  for (genvar g = 0; g < GAIN_N; g++) begin : gainBank
    logic [GAIN_W-1:0] q;
    logic              hit;
    assign hit = (stb.regSel == RN_GAIN_BASE + BYTE_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (stb.dataWr && hit) begin
        if (stb.hiByte) q[GAIN_W-1:BYTE_W] <= wdata;
        else            q[BYTE_W-1:0]      <= wdata;
      end
    end
    assign gainVec[g] = q;
  end

  // indirect read mux
  always_comb begin
    rdByte = '0;
    case (stb.regSel)
      RN_INIT:      rdByte = initQ;
      RN_MUX_ROUTE: rdByte = muxRouteQ;
      RN_MUX_CTL:   rdByte = muxCtlQ;
      RN_MODE1:     rdByte = mode1Q;
      RN_MODE2:     rdByte = mode2Q;
      default: begin
        for (int g = 0; g < GAIN_N; g++) begin
          if (stb.regSel == RN_GAIN_BASE + BYTE_W'(g))
            rdByte = stb.hiByte ? gainVec[g][GAIN_W-1:BYTE_W] : gainVec[g][BYTE_W-1:0];
        end
      end
    endcase
  end

  // interrupt latch, cleared on read, new events kept
  always_ff @(posedge clk) begin
    if (!rstN)          pendQ <= '0;
    else if (stb.irqRd) pendQ <= irqSrc;
    else                pendQ <= pendQ | irqSrc;
  end

  assign irqOut = (|pendQ) && !initQ[INIT_IRQ_OFF_BIT];
  assign rdata  = stb.irqRd ? pendQ : (stb.dataRd ? rdByte : '0);
endmodule

// File: rtl/irp_top.sv
module irp_top
  import irp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic [7:0]  irqSrc,
  output logic        irqOut,
  output logic [7:0]  initReg,
  output logic [7:0]  muxRoute,
  output logic [7:0]  muxCtl,
  output logic [7:0]  apMode1,
  output logic [7:0]  apMode2,
  output logic [15:0] txGain,
  output logic [15:0] rxGain,
  output logic [15:0] extGain,
  output logic [15:0] sideGain
);
  strobe_t stb;
  logic [GAIN_N-1:0][GAIN_W-1:0] gainVec;

  irp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .stb(stb)
  );

  irp_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .irqSrc(irqSrc),
    .rdata(busRdata), .irqOut(irqOut), .initQ(initReg), .muxRouteQ(muxRoute),
    .muxCtlQ(muxCtl), .mode1Q(apMode1), .mode2Q(apMode2), .gainVec(gainVec)
  );

  assign txGain   = gainVec[0];
  assign rxGain   = gainVec[1];
  assign extGain  = gainVec[2];
  assign sideGain = gainVec[3];
endmodule

// File: rtl/irp_checker.sv
module irp_checker (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  busAddr,
  input logic        busWr,
  input logic        busRd,
  input logic [7:0]  irqSrc,
  input logic        irqOut,
  input logic [7:0]  initReg,
  input logic [7:0]  muxRoute,
  input logic [7:0]  muxCtl,
  input logic [7:0]  apMode1,
  input logic [7:0]  apMode2,
  input logic [15:0] txGain,
  input logic [15:0] rxGain,
  input logic [15:0] extGain,
  input logic [15:0] sideGain
);
  logic [103:0] cfgAll;
  assign cfgAll = {initReg, muxRoute, muxCtl, apMode1, apMode2,
                   txGain, rxGain, extGain, sideGain};

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busAddr == 3'd0 && irqSrc == 8'h00) |=> !irqOut);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !initReg[2]);

  // R7
  event_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqSrc) |=> (irqOut || initReg[2]));

  // R9
  direct_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr >= 3'd2) |=> $stable(cfgAll));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == 3'd1) |=> $stable(cfgAll));
endmodule

bind irp_top irp_checker uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .irqSrc(irqSrc), .irqOut(irqOut), .initReg(initReg), .muxRoute(muxRoute),
  .muxCtl(muxCtl), .apMode1(apMode1), .apMode2(apMode2), .txGain(txGain),
  .rxGain(rxGain), .extGain(extGain), .sideGain(sideGain)
);

// File: tb/tb_irp_top.sv
module tb_irp_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  irqSrc = '0;
  logic        irqOut;
  logic [7:0]  initReg, muxRoute, muxCtl, apMode1, apMode2;
  logic [15:0] txGain, rxGain, extGain, sideGain;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irp_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irqSrc(irqSrc), .irqOut(irqOut),
    .initReg(initReg), .muxRoute(muxRoute), .muxCtl(muxCtl), .apMode1(apMode1),
    .apMode2(apMode2), .txGain(txGain), .rxGain(rxGain), .extGain(extGain),
    .sideGain(sideGain)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [7:0] src, output logic [7:0] d);
    busAddr = a; busRd = 1'b1; irqSrc = src;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0; irqSrc = '0;
  endtask

  task automatic pulse(input logic [7:0] src);
    irqSrc = src;
    @(negedge clk);
    irqSrc = '0;
  endtask

  function automatic bit isByteReg(input int n);
    return n == 'h21 || n == 'h41 || n == 'h44 || n == 'h69 || n == 'h6A;
  endfunction

  function automatic bit isGain(input int n);
    return n >= 'h63 && n <= 'h66;
  endfunction

  function automatic logic [7:0] patLo(input int n);
    return 8'(n) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] patHi(input int n);
    return 8'(n) ^ 8'h3C;
  endfunction

  logic [103:0] snap;
  function automatic logic [103:0] cfgNow();
    return {initReg, muxRoute, muxCtl, apMode1, apMode2, txGain, rxGain, extGain, sideGain};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg", 32'(cfgNow() == '0), 32'd1);
    check("R1 irqOut", {31'd0, irqOut}, 32'd0);
    check("R1 idle rdata", {24'd0, busRdata}, 32'd0);
    busRead(3'd0, 8'h00, rd);
    check("R1 status", {24'd0, rd}, 32'd0);

    // R2 R3 R5: write all 256 register numbers
    for (int n = 0; n < 256; n++) begin
      busWrite(3'd0, 8'(n));
      busWrite(3'd1, patLo(n));
      if (isGain(n)) busWrite(3'd1, patHi(n));
    end
    // R5 R2 R3: outputs hold only the implemented writes
    check("R2 initReg", {24'd0, initReg}, {24'd0, patLo('h21)});
    check("R2 muxRoute", {24'd0, muxRoute}, {24'd0, patLo('h41)});
    check("R2 muxCtl", {24'd0, muxCtl}, {24'd0, patLo('h44)});
    check("R2 apMode1", {24'd0, apMode1}, {24'd0, patLo('h69)});
    check("R2 apMode2", {24'd0, apMode2}, {24'd0, patLo('h6A)});
    check("R3 txGain", {16'd0, txGain}, {16'd0, patHi('h63), patLo('h63)});
    check("R3 rxGain", {16'd0, rxGain}, {16'd0, patHi('h64), patLo('h64)});
    check("R3 extGain", {16'd0, extGain}, {16'd0, patHi('h65), patLo('h65)});
    check("R3 sideGain", {16'd0, sideGain}, {16'd0, patHi('h66), patLo('h66)});

    // read back every number (R2 R3 R5)
    for (int n = 0; n < 256; n++) begin
      busWrite(3'd0, 8'(n));
      busRead(3'd1, 8'h00, rd);
      if (isGain(n)) begin
        check("R3 lo read", {24'd0, rd}, {24'd0, patLo(n)});
        busRead(3'd1, 8'h00, rd);
        check("R3 hi read", {24'd0, rd}, {24'd0, patHi(n)});
      end else if (isByteReg(n)) begin
        check("R2 read", {24'd0, rd}, {24'd0, patLo(n)});
      end else begin
        check("R5 unimpl read", {24'd0, rd}, 32'd0);
      end
    end

    // R4: re-issued command returns to low byte
    busWrite(3'd0, 8'h64);
    busWrite(3'd1, 8'h11);
    busWrite(3'd0, 8'h64);
    busWrite(3'd1, 8'h22);
    check("R4 rxGain", {16'd0, rxGain}, {16'd0, patHi('h64), 8'h22});

    // R10: third access wraps
    busWrite(3'd0, 8'h65);
    busWrite(3'd1, 8'h01);
    busWrite(3'd1, 8'h02);
    busWrite(3'd1, 8'h03);
    check("R10 extGain", {16'd0, extGain}, 32'h0203);

    // R9: other offsets ignored, pointer untouched
    busWrite(3'd0, 8'h66);
    busWrite(3'd1, 8'h5A);
    snap = cfgNow();
    for (int a = 2; a < 8; a++) begin
      busWrite(3'(a), 8'hFF);
      busRead(3'(a), 8'h00, rd);
      check("R9 read", {24'd0, rd}, 32'd0);
    end
    check("R9 cfg stable", 32'(cfgNow() == snap), 32'd1);
    busWrite(3'd1, 8'hC3);
    check("R9 pointer kept", {16'd0, sideGain}, 32'hC35A);

    // enable interrupts
    busWrite(3'd0, 8'h21);
    busWrite(3'd1, 8'h01);

    // R6: each source bit alone
    for (int b = 0; b < 8; b++) begin
      pulse(8'(1 << b));
      check("R6 irqOut set", {31'd0, irqOut}, 32'd1);
      busRead(3'd0, 8'h00, rd);
      check("R6 status", {24'd0, rd}, 32'(1 << b));
      check("R6 cleared", {31'd0, irqOut}, 32'd0);
    end
    // R6: accumulation
    pulse(8'h02);
    pulse(8'h90);
    busRead(3'd0, 8'h00, rd);
    check("R6 accumulate", {24'd0, rd}, 32'h92);

    // R7: event during clearing read
    pulse(8'h12);
    busRead(3'd0, 8'h40, rd);
    check("R7 returned", {24'd0, rd}, 32'h12);
    check("R7 irqOut kept", {31'd0, irqOut}, 32'd1);
    busRead(3'd0, 8'h00, rd);
    check("R7 pending", {24'd0, rd}, 32'h40);

    // R8: masking
    busWrite(3'd0, 8'h21);
    busWrite(3'd1, 8'h05);
    pulse(8'h20);
    check("R8 masked", {31'd0, irqOut}, 32'd0);
    busWrite(3'd0, 8'h21);
    busWrite(3'd1, 8'h01);
    check("R8 unmasked", {31'd0, irqOut}, 32'd1);
    busRead(3'd0, 8'h00, rd);
    check("R8 kept bits", {24'd0, rd}, 32'h20);
    check("R8 low", {31'd0, irqOut}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule